// File: doc/BRIEF.md
# Neighbor-Mirrored Lookup RAM with Access Events

This block is the private lookup RAM of one processor core. It stores 512 words of 32 bits and serves the core through a local write port and a local read port, plus a second read port for a streaming reader that walks the RAM as a circular buffer. The adjacent core can also write into this RAM. Each time it writes its own lookup RAM, the same word can land at the same address here, so that two cooperating cores share a window of table space without going through main memory.

A share limit says how many addresses, counted upward from address 0, accept those mirrored writes. After reset the limit is zero and nothing from the neighbor gets in. Alongside the storage, the block watches the access streams. One matched event fires when a chosen address is read. Another fires when a chosen address is written. Each is armed either by this core's own access or by the neighbor's access. A fixed event fires when the streamer fetches the top address, which tells software to refill the buffer. Each event gives a one-cycle pulse and sets a sticky flag that software clears by writing a one.

The event logic registers the access address and enable first and compares them against the target on the next clock. Each event therefore comes one cycle after the access that causes it. This keeps the comparator off the late-arriving address path.

Top module: `lut_mirror`

## Requirements
- R1: Local writes take effect at the clock edge. A local read returns on `loc_rd_data` one cycle after `loc_rd_en`. A read of an address that is written in the same cycle returns the data held before that write. `loc_rd_data` holds its value while no read is issued, and it resets to 0.
- R2: The streamer read port `strm_rd_data` has the same one-cycle latency and old-data behaviour. It resets to 0.
- R3: A neighbor write (`nbr_wr_en`) to address A stores `nbr_wr_data` at address A only when A is below the share limit. Otherwise the RAM is left unchanged.
- R4: The share limit resets to 0, so no neighbor write reaches the RAM until the limit is programmed.
- R5: A pulse on `share_cfg_we` loads the 10-bit `share_cfg_val` as the new limit, and any value above 512 is clamped to 512. A limit of 1 admits address 0 only, and 512 admits every address. The new limit governs neighbor writes from the following cycle.
- R6: When a local write and an admitted neighbor write hit the same address in the same cycle, the local data is stored and the neighbor data is dropped.
- R7: The read event (`evt_cfg_kind`=0) has a 9-bit target and a source bit (`evt_cfg_src` 0 = local read port, 1 = neighbor read). `evt_rd_pulse` is high for exactly the cycle after a read by the selected source at the target. An access in the same cycle as a configuration write is judged against the new configuration. At reset the target is address 0 and the source is local.
- R8: The write event (`evt_cfg_kind`=1) behaves the same way for local writes (source 0) or neighbor writes (source 1). A neighbor write counts whether or not the share limit admits it.
- R9: `evt_strm_pulse` is high for exactly the cycle after a streamer read of address 0x1FF, and it stays low for any other address.
- R10: `evt_sticky` bit 0 (read), bit 1 (write) and bit 2 (streamer) is set in the cycle after its pulse and stays set until a cycle in which the same bit of `evt_clr` is 1 and no new pulse is present. A pulse wins over a clear in the same cycle. All sticky bits reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loc_rd_en | input | 1 | Local read request |
| loc_rd_addr | input | 9 | Local read address |
| loc_rd_data | output | 32 | Local read data, one cycle after request |
| loc_wr_en | input | 1 | Local write strobe |
| loc_wr_addr | input | 9 | Local write address |
| loc_wr_data | input | 32 | Local write data |
| strm_rd_en | input | 1 | Streamer read request |
| strm_rd_addr | input | 9 | Streamer read address |
| strm_rd_data | output | 32 | Streamer read data, one cycle after request |
| nbr_rd_en | input | 1 | Neighbor core is reading its own RAM |
| nbr_rd_addr | input | 9 | Neighbor read address |
| nbr_wr_en | input | 1 | Neighbor core is writing its own RAM |
| nbr_wr_addr | input | 9 | Neighbor write address |
| nbr_wr_data | input | 32 | Neighbor write data |
| share_cfg_we | input | 1 | Load the share limit |
| share_cfg_val | input | 10 | Requested share limit (clamped to 512) |
| evt_cfg_we | input | 1 | Load one matched-event configuration |
| evt_cfg_kind | input | 1 | 0 = read event, 1 = write event |
| evt_cfg_addr | input | 9 | Event target address |
| evt_cfg_src | input | 1 | 0 = local access, 1 = neighbor access |
| evt_clr | input | 3 | Write-one-to-clear for the sticky flags |
| evt_rd_pulse | output | 1 | Read event pulse |
| evt_wr_pulse | output | 1 | Write event pulse |
| evt_strm_pulse | output | 1 | Streamer top-address event pulse |
| evt_sticky | output | 3 | Sticky flags {streamer, write, read} |

## Verification
The bench builds the block with its default 9-bit address and 32-bit data. At that size the top address 0x1FF, which triggers the streamer event, is reachable. So are the limit values 0, 1, 512 and the clamped values above 512. Directed sequences cover empty, single-word and full sharing, collisions between local and neighbor writes, read-during-write, and each event source. A long random phase then concentrates addresses near both ends of the RAM, so that event matches, admitted and rejected neighbor writes, and same-address collisions happen often.

// File: rtl/lut_mirror_pkg.sv
package lut_mirror_pkg;

  typedef enum logic {
    SRC_LOCAL    = 1'b0,
    SRC_NEIGHBOR = 1'b1
  } evt_src_e;

  localparam int EVT_RD  = 0;
  localparam int EVT_WR  = 1;
  localparam int EVT_ST  = 2;
  localparam int NUM_EVT = 3;

endpackage

// File: rtl/lut_mirror_share.sv
module lut_mirror_share #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W:0]   cfg_val,
  input  logic              nbr_wr_en,
  input  logic [ADDR_W-1:0] nbr_wr_addr,
  output logic              mirror_ok
);
  localparam int              SHARE_W = ADDR_W + 1;
  localparam logic [SHARE_W-1:0] SHARE_MAX = SHARE_W'(1) << ADDR_W;

  logic [SHARE_W-1:0] limit_q;
  logic [SHARE_W-1:0] limit_d;

  always_comb begin
    limit_d = limit_q;
    if (cfg_we) begin
      limit_d = (cfg_val > SHARE_MAX) ? SHARE_MAX : cfg_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) limit_q <= '0;
    else        limit_q <= limit_d;
  end

  assign mirror_ok = nbr_wr_en && ({1'b0, nbr_wr_addr} < limit_q);

endmodule

// File: rtl/lut_mirror_store.sv
module lut_mirror_store #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loc_wr_en,
  input  logic [ADDR_W-1:0] loc_wr_addr,
  input  logic [DATA_W-1:0] loc_wr_data,
  input  logic              mir_wr_en,
  input  logic [ADDR_W-1:0] mir_wr_addr,
  input  logic [DATA_W-1:0] mir_wr_data,
  input  logic              loc_rd_en,
  input  logic [ADDR_W-1:0] loc_rd_addr,
  output logic [DATA_W-1:0] loc_rd_data,
  input  logic              strm_rd_en,
  input  logic [ADDR_W-1:0] strm_rd_addr,
  output logic [DATA_W-1:0] strm_rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              mir_we;
  logic [DATA_W-1:0] loc_q, loc_d;
  logic [DATA_W-1:0] strm_q, strm_d;

  // local port owns the address when both writers collide
  always_comb begin
    mir_we = mir_wr_en && !(loc_wr_en && (loc_wr_addr == mir_wr_addr));
  end

  always_ff @(posedge clk) begin
    if (mir_we)    mem[mir_wr_addr] <= mir_wr_data;
    if (loc_wr_en) mem[loc_wr_addr] <= loc_wr_data;
  end

  always_comb begin
    loc_d  = loc_rd_en  ? mem[loc_rd_addr]  : loc_q;
    strm_d = strm_rd_en ? mem[strm_rd_addr] : strm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_q  <= '0;
      strm_q <= '0;
    end else begin
      loc_q  <= loc_d;
      strm_q <= strm_d;
    end
  end

  assign loc_rd_data  = loc_q;
  assign strm_rd_data = strm_q;

endmodule

// File: rtl/lut_mirror_evt_unit.sv
module lut_mirror_evt_unit
  import lut_mirror_pkg::*;
#(
  parameter int                ADDR_W   = 9,
  parameter logic [ADDR_W-1:0] RST_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  evt_src_e          cfg_src,
  input  logic              loc_en,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic              nbr_en,
  input  logic [ADDR_W-1:0] nbr_addr,
  input  logic              clr,
  output logic              pulse,
  output logic              sticky
);
  logic [ADDR_W-1:0] tgt_q, tgt_d;
  evt_src_e          src_q, src_d;
  logic              cap_en_q, cap_en_d;
  logic [ADDR_W-1:0] cap_addr_q, cap_addr_d;
  logic              sticky_q, sticky_d;
  logic              hit;

  always_comb begin
    tgt_d = tgt_q;
    src_d = src_q;
    if (cfg_we) begin
      tgt_d = cfg_addr;
      src_d = cfg_src;
    end
    // capture stage: only the selected source's access is registered
    cap_addr_d = cap_addr_q;
    if (src_d == SRC_NEIGHBOR) begin
      cap_en_d = nbr_en;
      if (nbr_en) cap_addr_d = nbr_addr;
    end else begin
      cap_en_d = loc_en;
      if (loc_en) cap_addr_d = loc_addr;
    end
    hit      = cap_en_q && (cap_addr_q == tgt_q);
    sticky_d = (sticky_q && !clr) || hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q      <= RST_ADDR;
      src_q      <= SRC_LOCAL;
      cap_en_q   <= 1'b0;
      cap_addr_q <= '0;
      sticky_q   <= 1'b0;
    end else begin
      tgt_q      <= tgt_d;
      src_q      <= src_d;
      cap_en_q   <= cap_en_d;
      cap_addr_q <= cap_addr_d;
      sticky_q   <= sticky_d;
    end
  end

  assign pulse  = hit;
  assign sticky = sticky_q;

endmodule

// File: rtl/lut_mirror.sv
module lut_mirror
  import lut_mirror_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loc_rd_en,
  input  logic [ADDR_W-1:0] loc_rd_addr,
  output logic [DATA_W-1:0] loc_rd_data,
  input  logic              loc_wr_en,
  input  logic [ADDR_W-1:0] loc_wr_addr,
  input  logic [DATA_W-1:0] loc_wr_data,
  input  logic              strm_rd_en,
  input  logic [ADDR_W-1:0] strm_rd_addr,
  output logic [DATA_W-1:0] strm_rd_data,
  input  logic              nbr_rd_en,
  input  logic [ADDR_W-1:0] nbr_rd_addr,
  input  logic              nbr_wr_en,
  input  logic [ADDR_W-1:0] nbr_wr_addr,
  input  logic [DATA_W-1:0] nbr_wr_data,
  input  logic              share_cfg_we,
  input  logic [ADDR_W:0]   share_cfg_val,
  input  logic              evt_cfg_we,
  input  logic              evt_cfg_kind,
  input  logic [ADDR_W-1:0] evt_cfg_addr,
  input  logic              evt_cfg_src,
  input  logic [2:0]        evt_clr,
  output logic              evt_rd_pulse,
  output logic              evt_wr_pulse,
  output logic              evt_strm_pulse,
  output logic [2:0]        evt_sticky
);
  localparam logic [ADDR_W-1:0] STRM_TOP = '1;

  logic mirror_ok;

  lut_mirror_share #(.ADDR_W(ADDR_W)) i_share (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (share_cfg_we),
    .cfg_val     (share_cfg_val),
    .nbr_wr_en   (nbr_wr_en),
    .nbr_wr_addr (nbr_wr_addr),
    .mirror_ok   (mirror_ok)
  );

  lut_mirror_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .loc_wr_en    (loc_wr_en),
    .loc_wr_addr  (loc_wr_addr),
    .loc_wr_data  (loc_wr_data),
    .mir_wr_en    (mirror_ok),
    .mir_wr_addr  (nbr_wr_addr),
    .mir_wr_data  (nbr_wr_data),
    .loc_rd_en    (loc_rd_en),
    .loc_rd_addr  (loc_rd_addr),
    .loc_rd_data  (loc_rd_data),
    .strm_rd_en   (strm_rd_en),
    .strm_rd_addr (strm_rd_addr),
    .strm_rd_data (strm_rd_data)
  );

  logic              ev_loc_en   [NUM_EVT];
  logic [ADDR_W-1:0] ev_loc_addr [NUM_EVT];
  logic              ev_nbr_en   [NUM_EVT];
  logic [ADDR_W-1:0] ev_nbr_addr [NUM_EVT];
  logic [NUM_EVT-1:0] ev_pulse;
  logic [NUM_EVT-1:0] ev_sticky;

  always_comb begin
    ev_loc_en[EVT_RD]   = loc_rd_en;
    ev_loc_addr[EVT_RD] = loc_rd_addr;
    ev_nbr_en[EVT_RD]   = nbr_rd_en;
    ev_nbr_addr[EVT_RD] = nbr_rd_addr;
    ev_loc_en[EVT_WR]   = loc_wr_en;
    ev_loc_addr[EVT_WR] = loc_wr_addr;
    ev_nbr_en[EVT_WR]   = nbr_wr_en;
    ev_nbr_addr[EVT_WR] = nbr_wr_addr;
    ev_loc_en[EVT_ST]   = strm_rd_en;
    ev_loc_addr[EVT_ST] = strm_rd_addr;
    ev_nbr_en[EVT_ST]   = 1'b0;
    ev_nbr_addr[EVT_ST] = '0;
  end

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
    if (g == EVT_ST) begin : g_fixed
      lut_mirror_evt_unit #(.ADDR_W(ADDR_W), .RST_ADDR(STRM_TOP)) i_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (1'b0),
        .cfg_addr (STRM_TOP),
        .cfg_src  (SRC_LOCAL),
        .loc_en   (ev_loc_en[g]),
        .loc_addr (ev_loc_addr[g]),
        .nbr_en   (ev_nbr_en[g]),
        .nbr_addr (ev_nbr_addr[g]),
        .clr      (evt_clr[g]),
        .pulse    (ev_pulse[g]),
        .sticky   (ev_sticky[g])
      );
    end else begin : g_match
      logic cfg_sel;
      assign cfg_sel = evt_cfg_we && (evt_cfg_kind == 1'(g));
      lut_mirror_evt_unit #(.ADDR_W(ADDR_W), .RST_ADDR('0)) i_unit (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_sel),
        .cfg_addr (evt_cfg_addr),
        .cfg_src  (evt_src_e'(evt_cfg_src)),
        .loc_en   (ev_loc_en[g]),
        .loc_addr (ev_loc_addr[g]),
        .nbr_en   (ev_nbr_en[g]),
        .nbr_addr (ev_nbr_addr[g]),
        .clr      (evt_clr[g]),
        .pulse    (ev_pulse[g]),
        .sticky   (ev_sticky[g])
      );
    end
  end

  assign evt_rd_pulse   = ev_pulse[EVT_RD];
  assign evt_wr_pulse   = ev_pulse[EVT_WR];
  assign evt_strm_pulse = ev_pulse[EVT_ST];
  assign evt_sticky     = ev_sticky;

endmodule

// File: rtl/lut_mirror_chk.sv
module lut_mirror_chk #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              loc_rd_en,
  input logic [DATA_W-1:0] loc_rd_data,
  input logic              nbr_rd_en,
  input logic              strm_rd_en,
  input logic [ADDR_W-1:0] strm_rd_addr,
  input logic [DATA_W-1:0] strm_rd_data,
  input logic [2:0]        evt_clr,
  input logic              evt_rd_pulse,
  input logic              evt_wr_pulse,
  input logic              evt_strm_pulse,
  input logic [2:0]        evt_sticky
);

  // R1: read data holds while no read is issued
  a_r1_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !loc_rd_en |=> $stable(loc_rd_data));

  // R2: streamer data holds while no streamer read is issued
  a_r2_strm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strm_rd_en |=> $stable(strm_rd_data));

  // R7: a read pulse needs a read access in the cycle before
  a_r7_rd_needs_access: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rd_pulse |-> $past(loc_rd_en || nbr_rd_en));

  // R9: top-address streamer read fires the streamer event next cycle
  a_r9_strm_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (strm_rd_en && (strm_rd_addr == '1)) |=> evt_strm_pulse);

  a_r9_strm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(strm_rd_en && (strm_rd_addr == '1)) |=> !evt_strm_pulse);

  // R10: sticky set, hold and clear
  a_r10_sticky_set_rd: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rd_pulse |=> evt_sticky[0]);

  a_r10_sticky_set_wr: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wr_pulse |=> evt_sticky[1]);

  a_r10_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_sticky[2] && !evt_clr[2]) |=> evt_sticky[2]);

  a_r10_sticky_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_clr[0] && !evt_rd_pulse) |=> !evt_sticky[0]);

endmodule

bind lut_mirror lut_mirror_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .loc_rd_en      (loc_rd_en),
  .loc_rd_data    (loc_rd_data),
  .nbr_rd_en      (nbr_rd_en),
  .strm_rd_en     (strm_rd_en),
  .strm_rd_addr   (strm_rd_addr),
  .strm_rd_data   (strm_rd_data),
  .evt_clr        (evt_clr),
  .evt_rd_pulse   (evt_rd_pulse),
  .evt_wr_pulse   (evt_wr_pulse),
  .evt_strm_pulse (evt_strm_pulse),
  .evt_sticky     (evt_sticky)
);

// File: tb/test_lut_mirror.sv
`timescale 1ns/100ps
module test_lut_mirror;
  localparam int AW = 9;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          loc_rd_en, loc_wr_en, strm_rd_en, nbr_rd_en, nbr_wr_en;
  logic [AW-1:0] loc_rd_addr, loc_wr_addr, strm_rd_addr, nbr_rd_addr, nbr_wr_addr;
  logic [DW-1:0] loc_wr_data, nbr_wr_data;
  logic [DW-1:0] loc_rd_data, strm_rd_data;
  logic          share_cfg_we;
  logic [AW:0]   share_cfg_val;
  logic          evt_cfg_we, evt_cfg_kind, evt_cfg_src;
  logic [AW-1:0] evt_cfg_addr;
  logic [2:0]    evt_clr;
  logic          evt_rd_pulse, evt_wr_pulse, evt_strm_pulse;
  logic [2:0]    evt_sticky;

  always #2.5 clk = ~clk;

  lut_mirror #(.ADDR_W(AW), .DATA_W(DW)) i_lut_mirror (
    .clk(clk), .rst_n(rst_n),
    .loc_rd_en(loc_rd_en), .loc_rd_addr(loc_rd_addr), .loc_rd_data(loc_rd_data),
    .loc_wr_en(loc_wr_en), .loc_wr_addr(loc_wr_addr), .loc_wr_data(loc_wr_data),
    .strm_rd_en(strm_rd_en), .strm_rd_addr(strm_rd_addr), .strm_rd_data(strm_rd_data),
    .nbr_rd_en(nbr_rd_en), .nbr_rd_addr(nbr_rd_addr),
    .nbr_wr_en(nbr_wr_en), .nbr_wr_addr(nbr_wr_addr), .nbr_wr_data(nbr_wr_data),
    .share_cfg_we(share_cfg_we), .share_cfg_val(share_cfg_val),
    .evt_cfg_we(evt_cfg_we), .evt_cfg_kind(evt_cfg_kind),
    .evt_cfg_addr(evt_cfg_addr), .evt_cfg_src(evt_cfg_src),
    .evt_clr(evt_clr),
    .evt_rd_pulse(evt_rd_pulse), .evt_wr_pulse(evt_wr_pulse),
    .evt_strm_pulse(evt_strm_pulse), .evt_sticky(evt_sticky)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string cur_tag = "R1";

  // reference model state
  logic [DW-1:0] m_mem [int];
  logic [DW-1:0] m_rd, m_strm;
  bit            m_rd_ok, m_strm_ok;
  int            m_share;
  int            m_tgt [2];
  bit            m_src [2];
  bit            m_rd_p, m_wr_p, m_st_p;
  logic [2:0]    m_sticky;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic idle();
    loc_rd_en = 0; loc_wr_en = 0; strm_rd_en = 0; nbr_rd_en = 0; nbr_wr_en = 0;
    loc_rd_addr = 0; loc_wr_addr = 0; strm_rd_addr = 0; nbr_rd_addr = 0; nbr_wr_addr = 0;
    loc_wr_data = 0; nbr_wr_data = 0;
    share_cfg_we = 0; share_cfg_val = 0;
    evt_cfg_we = 0; evt_cfg_kind = 0; evt_cfg_addr = 0; evt_cfg_src = 0;
    evt_clr = 0;
  endtask

  task automatic model_step();
    int la, na;
    m_sticky = (m_sticky & ~evt_clr) | {m_st_p, m_wr_p, m_rd_p};
    if (evt_cfg_we) begin
      m_tgt[evt_cfg_kind] = int'(evt_cfg_addr);
      m_src[evt_cfg_kind] = evt_cfg_src;
    end
    m_rd_p = m_src[0] ? (nbr_rd_en && int'(nbr_rd_addr) == m_tgt[0])
                      : (loc_rd_en && int'(loc_rd_addr) == m_tgt[0]);
    m_wr_p = m_src[1] ? (nbr_wr_en && int'(nbr_wr_addr) == m_tgt[1])
                      : (loc_wr_en && int'(loc_wr_addr) == m_tgt[1]);
    m_st_p = strm_rd_en && (int'(strm_rd_addr) == 511);
    if (loc_rd_en) begin
      la = int'(loc_rd_addr);
      m_rd_ok = m_mem.exists(la);
      if (m_rd_ok) m_rd = m_mem[la];
    end
    if (strm_rd_en) begin
      la = int'(strm_rd_addr);
      m_strm_ok = m_mem.exists(la);
      if (m_strm_ok) m_strm = m_mem[la];
    end
    na = int'(nbr_wr_addr);
    if (nbr_wr_en && na < m_share) m_mem[na] = nbr_wr_data;
    if (loc_wr_en) m_mem[int'(loc_wr_addr)] = loc_wr_data;
    if (share_cfg_we) m_share = (int'(share_cfg_val) > 512) ? 512 : int'(share_cfg_val);
  endtask

  task automatic compare();
    if (m_rd_ok)   chk(loc_rd_data == m_rd, cur_tag, loc_rd_data, m_rd);
    if (m_strm_ok) chk(strm_rd_data == m_strm, "R2 streamer data", strm_rd_data, m_strm);
    chk(evt_rd_pulse == m_rd_p, "R7 read event", 32'(evt_rd_pulse), 32'(m_rd_p));
    chk(evt_wr_pulse == m_wr_p, "R8 write event", 32'(evt_wr_pulse), 32'(m_wr_p));
    chk(evt_strm_pulse == m_st_p, "R9 streamer event", 32'(evt_strm_pulse), 32'(m_st_p));
    chk(evt_sticky == m_sticky, "R10 sticky", 32'(evt_sticky), 32'(m_sticky));
  endtask

  // inputs are set at the falling edge before each call
  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    idle();
  endtask

  function automatic logic [AW-1:0] pick();
    if ($urandom_range(0, 1) == 0) return AW'($urandom_range(0, 5));
    return AW'($urandom_range(506, 511));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    m_rd = 0; m_strm = 0; m_rd_ok = 1; m_strm_ok = 1;
    m_share = 0; m_tgt[0] = 0; m_tgt[1] = 0; m_src[0] = 0; m_src[1] = 0;
    m_rd_p = 0; m_wr_p = 0; m_st_p = 0; m_sticky = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state (R1, R2, R10)
    chk(loc_rd_data == 0, "R1 reset read data", loc_rd_data, 0);
    chk(strm_rd_data == 0, "R2 reset streamer data", strm_rd_data, 0);
    chk(evt_sticky == 0 && !evt_rd_pulse && !evt_wr_pulse && !evt_strm_pulse,
        "R10 reset events", {evt_sticky, evt_rd_pulse, evt_wr_pulse, evt_strm_pulse}, 0);

    // R1: seed words, read back, read during write
    cur_tag = "R1 local read";
    for (int a = 0; a < 6; a++) begin
      loc_wr_en = 1; loc_wr_addr = AW'(a); loc_wr_data = 32'h1000_0000 + a; cyc();
    end
    for (int a = 506; a < 512; a++) begin
      loc_wr_en = 1; loc_wr_addr = AW'(a); loc_wr_data = 32'h2000_0000 + a; cyc();
    end
    loc_rd_en = 1; loc_rd_addr = 3; cyc();
    loc_rd_en = 1; loc_rd_addr = 4; loc_wr_en = 1; loc_wr_addr = 4;
    loc_wr_data = 32'hAAAA_0004; cyc();
    loc_rd_en = 1; loc_rd_addr = 4; cyc();
    cyc();

    // R4: limit zero after reset blocks neighbor
    cur_tag = "R4 share reset";
    nbr_wr_en = 1; nbr_wr_addr = 0; nbr_wr_data = 32'hDEAD_0000; cyc();
    loc_rd_en = 1; loc_rd_addr = 0; cyc();

    // R5/R3: limit of 1 admits only address 0
    cur_tag = "R3 limit one";
    share_cfg_we = 1; share_cfg_val = 1;
    nbr_wr_en = 1; nbr_wr_addr = 0; nbr_wr_data = 32'hBEEF_0000; cyc();  // old limit
    nbr_wr_en = 1; nbr_wr_addr = 0; nbr_wr_data = 32'hBEEF_0001; cyc();
    nbr_wr_en = 1; nbr_wr_addr = 1; nbr_wr_data = 32'hBEEF_0002; cyc();
    loc_rd_en = 1; loc_rd_addr = 0; cyc();
    loc_rd_en = 1; loc_rd_addr = 1; cyc();

    // R5: clamp above 512 admits the top address
    cur_tag = "R5 clamp";
    share_cfg_we = 1; share_cfg_val = 10'd1000; cyc();
    nbr_wr_en = 1; nbr_wr_addr = 511; nbr_wr_data = 32'hC0DE_01FF; cyc();
    loc_rd_en = 1; loc_rd_addr = 511; cyc();
    cur_tag = "R5 limit 512";
    share_cfg_we = 1; share_cfg_val = 10'd512; cyc();
    nbr_wr_en = 1; nbr_wr_addr = 510; nbr_wr_data = 32'hC0DE_01FE; cyc();
    loc_rd_en = 1; loc_rd_addr = 510; cyc();

    // R6: collision, local wins
    cur_tag = "R6 collision";
    loc_wr_en = 1; loc_wr_addr = 2; loc_wr_data = 32'h1111_1111;
    nbr_wr_en = 1; nbr_wr_addr = 2; nbr_wr_data = 32'h2222_2222; cyc();
    loc_rd_en = 1; loc_rd_addr = 2; cyc();

    // R7: read event, local then neighbor source
    cur_tag = "R7 events";
    evt_cfg_we = 1; evt_cfg_kind = 0; evt_cfg_addr = 5; evt_cfg_src = 0; cyc();
    loc_rd_en = 1; loc_rd_addr = 5; cyc();
    loc_rd_en = 1; loc_rd_addr = 6; cyc();
    cyc();
    evt_cfg_we = 1; evt_cfg_kind = 0; evt_cfg_addr = 5; evt_cfg_src = 1;
    nbr_rd_en = 1; nbr_rd_addr = 5; cyc();
    loc_rd_en = 1; loc_rd_addr = 5; cyc();
    evt_clr = 3'b001; cyc();
    cyc();

    // R8: write event from neighbor even when limit blocks it
    cur_tag = "R8 events";
    share_cfg_we = 1; share_cfg_val = 0;
    evt_cfg_we = 1; evt_cfg_kind = 1; evt_cfg_addr = 9'h1F0; evt_cfg_src = 1; cyc();
    nbr_wr_en = 1; nbr_wr_addr = 9'h1F0; nbr_wr_data = 32'h5; cyc();
    loc_wr_en = 1; loc_wr_addr = 9'h1F0; loc_wr_data = 32'h6; cyc();
    evt_clr = 3'b010; nbr_wr_en = 1; nbr_wr_addr = 9'h1F0; cyc();
    cyc();

    // R9 / R10: streamer event, sticky set wins over clear
    cur_tag = "R9 streamer";
    strm_rd_en = 1; strm_rd_addr = 9'h1FE; cyc();
    strm_rd_en = 1; strm_rd_addr = 9'h1FF; cyc();
    evt_clr = 3'b100; cyc();
    cyc();
    evt_clr = 3'b100; cyc();
    cyc();

    // random phase
    cur_tag = "R3 random";
    for (int i = 0; i < 4000; i++) begin
      loc_rd_en = 1'($urandom); loc_rd_addr = pick();
      loc_wr_en = 1'($urandom); loc_wr_addr = pick(); loc_wr_data = $urandom;
      strm_rd_en = 1'($urandom); strm_rd_addr = pick();
      nbr_rd_en = 1'($urandom); nbr_rd_addr = pick();
      nbr_wr_en = 1'($urandom); nbr_wr_addr = pick(); nbr_wr_data = $urandom;
      if ($urandom_range(0, 31) == 0) begin
        share_cfg_we = 1;
        case ($urandom_range(0, 4))
          0: share_cfg_val = 0;
          1: share_cfg_val = 1;
          2: share_cfg_val = 10'd508;
          3: share_cfg_val = 10'd512;
          default: share_cfg_val = 10'($urandom_range(513, 1023));
        endcase
      end
      if ($urandom_range(0, 15) == 0) begin
        evt_cfg_we = 1; evt_cfg_kind = 1'($urandom);
        evt_cfg_addr = pick(); evt_cfg_src = 1'($urandom);
      end
      evt_clr = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000;
      cyc();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule